// File: doc/BRIEF.md
# Chained-State Command Byte Cipher

This block holds two byte-serial cipher lanes. The transmit lane scrambles plaintext command bytes on their way out. The receive lane turns scrambled reply bytes back into plaintext. Each lane keeps two 8-bit state registers, A and B, that link every byte to the bytes before it. The transmit lane computes a chain of wrapping add/subtract and XOR steps. The receive lane applies the exact inverse chain, with its state updates cross-coupled to match.

Each lane takes one byte per cycle through a valid/ready input. It presents the result one cycle later through a registered valid/ready output. A start-of-message flag travels with the first byte of a message, which is 1 to 64 bytes long. That byte is processed with the seed state A = 0x9B, B = 0x54, so no state carries over from one message to the next. Framing and the meaning of the commands are handled elsewhere.

Top module: `cc_cmd_cipher`

## Requirements
- R1: While reset is asserted and after it is released, both output valids are 0 and both input readies are 1. The state starts at the seeds (A = 0x9B, B = 0x54), so a first byte sent without the start flag is ciphered with the seeds. For example, a transmit byte 0x00 gives 0x DA, and a receive byte 0xDA gives 0x00.
- R2: The transmit lane maps input v to output t, with every operation taken modulo 256, as follows:
  - u = (((v ^ B ^ 0x2B) - 0x05) ^ 0x35) - 0x39
  - t = (((u ^ A ^ 0x5A) - 0xB0) ^ 0x38) - 0x45
- R3: After each accepted transmit byte, A takes the plaintext input v and B takes the output t.
- R4: The receive lane maps input v to output t, with every operation taken modulo 256, as follows:
  - u = ((((v + 0x45) ^ 0x38) + 0xB0) ^ 0x5A) ^ A
  - t = ((((u + 0x39) ^ 0x35) + 0x05) ^ 0x2B) ^ B
- R5: After each accepted receive byte, A takes the output t and B takes the received input v.
- R6: A byte accepted with the start flag set is processed with A = 0x9B and B = 0x54, whatever the state was before. Two messages with the same plaintext therefore give the same ciphertext, even when the second starts partway through the first.
- R7: A message of 1 to 64 bytes scrambled by the transmit lane and then fed, with the start flag on its first byte, into the receive lane comes back as the original bytes.
- R8: While an output is valid and its ready is low, the output byte and its valid hold. The input ready of that lane is low only while an output is held. No byte is lost or duplicated.
- R9: Cycles with input valid low do not change a lane's state, so a message may have idle gaps between its bytes.
- R10: A byte accepted at a clock edge appears on the lane output, with valid high, right after that edge. A lane never raises its output valid without an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_valid_i | input | 1 | Transmit plaintext byte valid |
| tx_sof_i | input | 1 | Transmit byte is the first byte of a message |
| tx_data_i | input | 8 | Transmit plaintext byte |
| tx_ready_o | output | 1 | Transmit lane can accept a byte |
| tx_out_valid_o | output | 1 | Scrambled byte valid |
| tx_out_data_o | output | 8 | Scrambled byte |
| tx_out_ready_i | input | 1 | Consumer takes the scrambled byte |
| rx_valid_i | input | 1 | Receive scrambled byte valid |
| rx_sof_i | input | 1 | Receive byte is the first byte of a message |
| rx_data_i | input | 8 | Receive scrambled byte |
| rx_ready_o | output | 1 | Receive lane can accept a byte |
| rx_out_valid_o | output | 1 | Recovered plaintext byte valid |
| rx_out_data_o | output | 8 | Recovered plaintext byte |
| rx_out_ready_i | input | 1 | Consumer takes the plaintext byte |

## Verification
The bench restarts a message in the middle of another and checks that the new message gets the same output as a clean start. A lane that ignored the start flag, or reloaded only one of its two registers, would produce different bytes there. It sends the very first byte after reset without a start flag, which catches a reset value that is not the seed pair. It round-trips messages of 1 and 64 bytes, and a mismatch there shows that the two lanes' state updates are not cross-coupled correctly. It also inserts idle gaps and applies random output backpressure, which exposes a lane that advances its state on an unaccepted cycle, or that drops or repeats bytes while stalled.

// File: rtl/cc_cipher_pkg.sv
package cc_cipher_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SEED_A = 8'h9B;
  localparam logic [BYTE_W-1:0] SEED_B = 8'h54;

  typedef enum logic {DIR_FWD = 1'b0, DIR_INV = 1'b1} dir_e;

  // scramble one byte with state pair (a, b)
  function automatic logic [BYTE_W-1:0] fwd_byte(input logic [BYTE_W-1:0] v,
                                                 input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] t;
    t = ((v ^ b ^ 8'h2B) - 8'h05) ^ 8'h35;
    t = t - 8'h39;
    t = ((t ^ a ^ 8'h5A) - 8'hB0) ^ 8'h38;
    t = t - 8'h45;
    return t;
  endfunction

  // undo fwd_byte given the same state pair
  function automatic logic [BYTE_W-1:0] inv_byte(input logic [BYTE_W-1:0] v,
                                                 input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] t;
    t = (((v + 8'h45) ^ 8'h38) + 8'hB0) ^ 8'h5A ^ a;
    t = (((t + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2B ^ b;
    return t;
  endfunction

endpackage

// File: rtl/cc_rst_sync.sv
module cc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/cc_cipher_lane.sv
module cc_cipher_lane
  import cc_cipher_pkg::*;
#(
  parameter dir_e MODE = DIR_FWD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  logic [BYTE_W-1:0] key_a_q, key_b_q, key_a_d, key_b_d;
  logic [BYTE_W-1:0] cur_a, cur_b, result;
  logic [BYTE_W-1:0] out_data_q;
  logic              out_valid_q, out_valid_d;
  logic              take;

  // ready whenever the output slot is empty or is being drained
  assign in_ready_o = ~out_valid_q | out_ready_i;
  assign take       = in_valid_i & in_ready_o;

  always_comb begin
    cur_a = in_sof_i ? SEED_A : key_a_q;
    cur_b = in_sof_i ? SEED_B : key_b_q;
  end

  generate
    if (MODE == DIR_FWD) begin : g_fwd
      always_comb begin
        result  = fwd_byte(in_data_i, cur_a, cur_b);
        key_a_d = in_data_i;
        key_b_d = result;
      end
    end else begin : g_inv
      always_comb begin
        result  = inv_byte(in_data_i, cur_a, cur_b);
        key_a_d = result;
        key_b_d = in_data_i;
      end
    end
  endgenerate

  always_comb begin
    out_valid_d = take | (out_valid_q & ~out_ready_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_a_q <= SEED_A;
      key_b_q <= SEED_B;
    end else if (take) begin
      key_a_q <= key_a_d;
      key_b_q <= key_b_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_data_q <= '0;
    else if (take) out_data_q <= result;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_q <= 1'b0;
    else         out_valid_q <= out_valid_d;
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
endmodule

// File: rtl/cc_cmd_cipher.sv
module cc_cmd_cipher
  import cc_cipher_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic              tx_sof_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              tx_out_valid_o,
  output logic [BYTE_W-1:0] tx_out_data_o,
  input  logic              tx_out_ready_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              rx_out_valid_o,
  output logic [BYTE_W-1:0] rx_out_data_o,
  input  logic              rx_out_ready_i
);
  logic rst_sync_n;

  cc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cc_cipher_lane #(.MODE(DIR_FWD)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .in_valid_i  (tx_valid_i),
    .in_sof_i    (tx_sof_i),
    .in_data_i   (tx_data_i),
    .in_ready_o  (tx_ready_o),
    .out_valid_o (tx_out_valid_o),
    .out_data_o  (tx_out_data_o),
    .out_ready_i (tx_out_ready_i)
  );

  cc_cipher_lane #(.MODE(DIR_INV)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .in_valid_i  (rx_valid_i),
    .in_sof_i    (rx_sof_i),
    .in_data_i   (rx_data_i),
    .in_ready_o  (rx_ready_o),
    .out_valid_o (rx_out_valid_o),
    .out_data_o  (rx_out_data_o),
    .out_ready_i (rx_out_ready_i)
  );
endmodule

// File: rtl/cc_cmd_cipher_chk.sv
module cc_cmd_cipher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_sof,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       tx_ovalid,
  input logic [7:0] tx_odata,
  input logic       tx_oready,
  input logic       rx_valid,
  input logic       rx_sof,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       rx_ovalid,
  input logic [7:0] rx_odata,
  input logic       rx_oready
);
  // held output keeps its byte (R8)
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovalid && !tx_oready |=> tx_ovalid && $stable(tx_odata));
  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovalid && !rx_oready |=> rx_ovalid && $stable(rx_odata));

  // ready drops only while an output is held (R8)
  assert_tx_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> tx_ovalid && !tx_oready);
  assert_rx_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> rx_ovalid && !rx_oready);

  // accepted byte shows up next cycle (R10)
  assert_tx_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> tx_ovalid);
  assert_rx_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> rx_ovalid);

  // no output without a cause (R10)
  assert_tx_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovalid |-> $past((tx_valid && tx_ready) || (tx_ovalid && !tx_oready)));
  assert_rx_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovalid |-> $past((rx_valid && rx_ready) || (rx_ovalid && !rx_oready)));

  // known vector from the seeds (R2, R6) and its inverse (R4, R6)
  assert_tx_seed_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_sof && tx_data == 8'h00 |=> tx_odata == 8'hDA);
  assert_rx_seed_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && rx_sof && rx_data == 8'hDA |=> rx_odata == 8'h00);
endmodule

bind cc_cmd_cipher cc_cmd_cipher_chk u_chk (
  .clk       (clk_i),
  .rst_n     (rst_sync_n),
  .tx_valid  (tx_valid_i),
  .tx_sof    (tx_sof_i),
  .tx_data   (tx_data_i),
  .tx_ready  (tx_ready_o),
  .tx_ovalid (tx_out_valid_o),
  .tx_odata  (tx_out_data_o),
  .tx_oready (tx_out_ready_i),
  .rx_valid  (rx_valid_i),
  .rx_sof    (rx_sof_i),
  .rx_data   (rx_data_i),
  .rx_ready  (rx_ready_o),
  .rx_ovalid (rx_out_valid_o),
  .rx_odata  (rx_out_data_o),
  .rx_oready (rx_out_ready_i)
);

// File: tb/cc_cmd_cipher_test.sv
`timescale 1ns/1ps
module cc_cmd_cipher_test;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       tx_valid = 0, tx_sof = 0, tx_ready, tx_ovalid, tx_oready = 1;
  logic [7:0] tx_data = 0, tx_odata;
  logic       rx_valid = 0, rx_sof = 0, rx_ready, rx_ovalid, rx_oready = 1;
  logic [7:0] rx_data = 0, rx_odata;

  int checks = 0;
  int errors = 0;
  bit bp_en  = 0;
  bit cap_en = 0;

  logic [7:0] m_tx_a = 8'h9B, m_tx_b = 8'h54, m_rx_a = 8'h9B, m_rx_b = 8'h54;
  logic [7:0] exp_tx[$], exp_rx[$], cap_tx[$], plain[$];
  string      tag_tx[$], tag_rx[$];

  always #2.5 clk = ~clk;

  cc_cmd_cipher uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_valid_i(tx_valid), .tx_sof_i(tx_sof), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .tx_out_valid_o(tx_ovalid), .tx_out_data_o(tx_odata), .tx_out_ready_i(tx_oready),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .rx_out_valid_o(rx_ovalid), .rx_out_data_o(rx_odata), .rx_out_ready_i(rx_oready)
  );

  // reference model written from R2 and R4
  function automatic logic [7:0] m_scr(input logic [7:0] v, a, b);
    logic [7:0] u;
    u = (((v ^ b ^ 8'h2B) - 8'h05) ^ 8'h35) - 8'h39;
    return (((u ^ a ^ 8'h5A) - 8'hB0) ^ 8'h38) - 8'h45;
  endfunction
  function automatic logic [7:0] m_uns(input logic [7:0] v, a, b);
    logic [7:0] u;
    u = ((((v + 8'h45) ^ 8'h38) + 8'hB0) ^ 8'h5A) ^ a;
    return ((((u + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2B) ^ b;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tx_send(input logic [7:0] d, input bit sof, input string tag, input int gap);
    logic [7:0] a, b, r;
    repeat (gap) @(negedge clk);
    a = sof ? 8'h9B : m_tx_a;
    b = sof ? 8'h54 : m_tx_b;
    r = m_scr(d, a, b);
    m_tx_a = d; m_tx_b = r;                 // R3
    exp_tx.push_back(r); tag_tx.push_back(tag);
    @(negedge clk);
    tx_valid = 1; tx_sof = sof; tx_data = d;
    #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    tx_valid = 0; tx_sof = 0;
    if (!bp_en) check("R10 tx valid after accept", {7'd0, tx_ovalid}, 8'd1);
  endtask

  task automatic rx_send(input logic [7:0] d, input bit sof, input bit use_exp,
                         input logic [7:0] e, input string tag, input int gap);
    logic [7:0] a, b, r;
    repeat (gap) @(negedge clk);
    a = sof ? 8'h9B : m_rx_a;
    b = sof ? 8'h54 : m_rx_b;
    r = m_uns(d, a, b);
    m_rx_a = r; m_rx_b = d;                 // R5
    exp_rx.push_back(use_exp ? e : r); tag_rx.push_back(tag);
    @(negedge clk);
    rx_valid = 1; rx_sof = sof; rx_data = d;
    #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rx_valid = 0; rx_sof = 0;
    if (!bp_en) check("R10 rx valid after accept", {7'd0, rx_ovalid}, 8'd1);
  endtask

  task automatic drain();
    for (int i = 0; i < 500 && (exp_tx.size() > 0 || exp_rx.size() > 0); i++) @(negedge clk);
    check("R8 tx nothing lost", 8'(exp_tx.size()), 8'd0);
    check("R8 rx nothing lost", 8'(exp_rx.size()), 8'd0);
  endtask

  // monitors: pop and compare as results leave the design
  initial begin
    forever begin
      @(negedge clk);
      tx_oready = bp_en ? (($urandom() % 3) != 0) : 1'b1;
      if (tx_ovalid && tx_oready) begin
        if (exp_tx.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 tx extra byte actual %02h expected none", tx_odata);
        end else begin
          check(tag_tx.pop_front(), tx_odata, exp_tx.pop_front());
          if (cap_en) cap_tx.push_back(tx_odata);
        end
      end
    end
  end
  initial begin
    forever begin
      @(negedge clk);
      rx_oready = bp_en ? (($urandom() % 3) != 0) : 1'b1;
      if (rx_ovalid && rx_oready) begin
        if (exp_rx.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 rx extra byte actual %02h expected none", rx_odata);
        end else check(tag_rx.pop_front(), rx_odata, exp_rx.pop_front());
      end
    end
  end

  // round trip of one message of n bytes (R7)
  task automatic round_trip(input int n);
    plain.delete(); cap_tx.delete();
    cap_en = 1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom());
      plain.push_back(d);
      tx_send(d, i == 0, "R2 round-trip scramble", 0);
    end
    drain();
    cap_en = 0;
    check("R7 captured length", 8'(cap_tx.size()), 8'(n));
    for (int i = 0; i < n && i < cap_tx.size(); i++)
      rx_send(cap_tx[i], i == 0, 1'b1, plain[i], "R7 round-trip plaintext", 0);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] msg[16];
    rst_ni = 0;
    repeat (3) @(negedge clk);
    check("R1 tx out valid in reset", {7'd0, tx_ovalid}, 8'd0);
    check("R1 rx out valid in reset", {7'd0, rx_ovalid}, 8'd0);
    check("R1 tx ready in reset", {7'd0, tx_ready}, 8'd1);
    check("R1 rx ready in reset", {7'd0, rx_ready}, 8'd1);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    check("R1 tx out valid after reset", {7'd0, tx_ovalid}, 8'd0);
    check("R1 rx out valid after reset", {7'd0, rx_ovalid}, 8'd0);

    // R1: first bytes without start flag use seed state
    tx_send(8'h00, 0, "R1 tx seed vector", 0);
    rx_send(8'hDA, 0, 1'b1, 8'h00, "R1 rx seed vector", 0);
    drain();

    // R2 R3: chained transmit message
    for (int i = 0; i < 16; i++) begin
      msg[i] = 8'($urandom());
      tx_send(msg[i], i == 0, "R3 tx chained", 0);
    end
    // R6: restart mid-message with the same plaintext
    for (int i = 0; i < 7; i++) tx_send(msg[i], i == 0, "R6 tx partial", 0);
    for (int i = 0; i < 16; i++) tx_send(msg[i], i == 0, "R6 tx restart", 0);
    drain();

    // R4 R5: chained receive message, then restart
    for (int i = 0; i < 16; i++) rx_send(msg[i], i == 0, 1'b0, 8'h00, "R5 rx chained", 0);
    for (int i = 0; i < 5; i++) rx_send(msg[i], i == 0, 1'b0, 8'h00, "R6 rx restart", 0);
    drain();

    // R9: idle gaps inside messages
    for (int i = 0; i < 12; i++) tx_send(8'($urandom()), i == 0, "R9 tx gaps", $urandom() % 4);
    for (int i = 0; i < 12; i++) rx_send(8'($urandom()), i == 0, 1'b0, 8'h00, "R9 rx gaps", $urandom() % 4);
    drain();

    // R8: random output backpressure
    bp_en = 1;
    for (int i = 0; i < 64; i++) tx_send(8'($urandom()), i == 0, "R8 tx backpressure", 0);
    for (int i = 0; i < 40; i++) rx_send(8'($urandom()), i == 0, 1'b0, 8'h00, "R8 rx backpressure", 0);
    drain();
    bp_en = 0;
    repeat (2) @(negedge clk);

    // R7: round trips, shortest and longest plus random lengths
    round_trip(1);
    round_trip(64);
    for (int k = 0; k < 4; k++) round_trip(1 + ($urandom() % 64));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule